// File: doc/BRIEF.md
# Serial Register Access Master

This block sits on the link-layer side of a single shared, bidirectional register line that runs on the interface clock. A request carries an access direction, an 8-bit register address and, for writes, an 8-bit value. Once the master accepts a request, it sends a frame on the line one bit per clock. The frame opens with a high start bit. A direction bit follows, high for a read. Then comes the address, most significant bit first.

On a write, the master keeps control of the line and sends the eight value bits straight after the address. On a read, the master lets go of the line for one turnaround cycle. It then samples eight bits driven by the far end and presents the assembled byte with a one-cycle valid strobe. Every frame ends with a zero that the master drives itself, after which the line is released.

The block exposes only the tristate controls for the line (enable and value) and a raw sample input. The pad and any pull resistor sit outside the block. Requests are taken only while the block is idle.

Top module: `sra_master`

## Requirements
- R1: After reset and between frames, `busy_o` is 0, `sdio_oe_o` is 0 and `rvalid_o` is 0. An asynchronous reset during a frame releases the line at once.
- R2: In the first clock after a request is accepted (`req_i`=1 with `busy_o`=0 at a rising edge), `busy_o` is 1 and the line is driven with value 1 (start bit).
- R3: In the second cycle the line is driven with the direction bit: 1 when `we_i` was 0 (read) and 0 when `we_i` was 1 (write).
- R4: Cycles 3 to 10 drive the 8 address bits, bit 7 first.
- R5: For a write, cycles 11 to 18 drive the 8 value bits, bit 7 first, and `sdio_oe_o` stays 1 with no gap from the start bit to the end of the frame.
- R6: For a read, cycle 11 is a turnaround with `sdio_oe_o`=0, and cycles 12 to 19 also keep `sdio_oe_o`=0 while `sdio_i` is sampled at the rising edge closing each cycle.
- R7: The read byte is assembled with the first sampled bit as bit 7. It appears on `rdata_o` together with a single-cycle `rvalid_o` pulse in the cycle right after the last data bit.
- R8: The last cycle of every frame drives value 0 with `sdio_oe_o`=1 (cycle 19 for a write, cycle 20 for a read). The line is released in the next cycle.
- R9: `req_i` is ignored while `busy_o` is 1. A request raised during a frame neither changes that frame nor starts another one afterwards.
- R10: `busy_o` stays high for exactly 19 cycles per write and 20 per read. A request held high starts the next frame after exactly one idle cycle.
- R11: `rdata_o` changes only in a cycle where `rvalid_o` is 1. Writes leave it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when `busy_o` is 0 |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write value |
| sdio_i | input | 1 | Sampled level of the shared line |
| sdio_oe_o | output | 1 | Line drive enable |
| sdio_do_o | output | 1 | Line drive value |
| busy_o | output | 1 | Frame in progress |
| rvalid_o | output | 1 | Read byte valid strobe |
| rdata_o | output | 8 | Last read byte |

## Verification
The hardest situation to reach from the ports is a request that arrives at the exact edge where the frame is handing over to idle. The refusal has to hold on the terminating cycle, and a request held high has to be taken one idle cycle later, not two. The stimulus raises `req_i` in the final cycle of a frame and then holds it through the next frame boundary, checking the idle gap cycle by cycle. Read data is produced by a responder model in the bench. It stores every written value, so each read-back proves that the write bits were framed correctly end to end. Reads of untouched addresses return a known seeded pattern.

// File: rtl/sra_pkg.sv
`timescale 1ns/1ps
package sra_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DIR,
    PH_ADDR,
    PH_WDATA,
    PH_TURN,
    PH_RDATA,
    PH_TERM
  } phase_e;
endpackage

// File: rtl/sra_seq.sv
`timescale 1ns/1ps
module sra_seq
  import sra_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int MAXW = (AW > DW) ? AW : DW,
  localparam int CW = (MAXW > 1) ? $clog2(MAXW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  output logic          accept_o,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          wr_o
);
  localparam logic [CW-1:0] ALAST = CW'(AW - 1);
  localparam logic [CW-1:0] DLAST = CW'(DW - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q;

  assign accept_o = (ph_q == PH_IDLE) && req_i;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE:  if (req_i) ph_d = PH_START;
      PH_START: ph_d = PH_DIR;
      PH_DIR: begin
        ph_d  = PH_ADDR;
        cnt_d = ALAST;
      end
      PH_ADDR: begin
        if (cnt_q == '0) begin
          ph_d  = wr_q ? PH_WDATA : PH_TURN;
          cnt_d = DLAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_WDATA: begin
        if (cnt_q == '0) ph_d = PH_TERM;
        else cnt_d = cnt_q - 1'b1;
      end
      PH_TURN: begin
        ph_d  = PH_RDATA;
        cnt_d = DLAST;
      end
      PH_RDATA: begin
        if (cnt_q == '0) ph_d = PH_TERM;
        else cnt_d = cnt_q - 1'b1;
      end
      PH_TERM:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (accept_o) wr_q <= we_i;
    end
  end

  assign phase_o = ph_q;
  assign cnt_o   = cnt_q;
  assign wr_o    = wr_q;
endmodule

// File: rtl/sra_txshift.sv
`timescale 1ns/1ps
module sra_txshift #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int SW = AW + DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          bit_o
);
  logic [SW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= {addr_i, wdata_i};
    else if (shift_i) sr_q <= {sr_q[SW-2:0], 1'b0};
  end

  assign bit_o = sr_q[SW-1];
endmodule

// File: rtl/sra_rxshift.sv
`timescale 1ns/1ps
module sra_rxshift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic          last_i,
  input  logic          sdio_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-2:0] acc_q;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= sample_i && last_i;
      if (sample_i) begin
        acc_q <= {acc_q[DW-3:0], sdio_i};
        if (last_i) rdata_q <= {acc_q, sdio_i};
      end
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/sra_master.sv
`timescale 1ns/1ps
module sra_master
  import sra_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int MAXW = (AW > DW) ? AW : DW,
  localparam int CW = (MAXW > 1) ? $clog2(MAXW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sdio_i,
  output logic          sdio_oe_o,
  output logic          sdio_do_o,
  output logic          busy_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          accept, wr, tx_bit;

  sra_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .accept_o (accept),
    .phase_o  (phase),
    .cnt_o    (cnt),
    .wr_o     (wr)
  );

  sra_txshift #(.AW(AW), .DW(DW)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shift_i ((phase == PH_ADDR) || (phase == PH_WDATA)),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .bit_o   (tx_bit)
  );

  sra_rxshift #(.DW(DW)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (phase == PH_RDATA),
    .last_i   (cnt == '0),
    .sdio_i   (sdio_i),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o)
  );

  always_comb begin
    sdio_oe_o = 1'b1;
    sdio_do_o = 1'b0;
    unique case (phase)
      PH_START:            sdio_do_o = 1'b1;
      PH_DIR:              sdio_do_o = ~wr;
      PH_ADDR, PH_WDATA:   sdio_do_o = tx_bit;
      PH_TERM:             sdio_do_o = 1'b0;
      default:             sdio_oe_o = 1'b0;  // idle, turnaround, read data
    endcase
  end

  assign busy_o = (phase != PH_IDLE);
endmodule

// File: rtl/sra_master_chk.sv
`timescale 1ns/1ps
module sra_master_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          sdio_oe_o,
  input logic          sdio_do_o,
  input logic          rvalid_o,
  input logic [DW-1:0] rdata_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sdio_oe_o && !rvalid_o));

  p_start_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (sdio_oe_o && sdio_do_o));

  p_rvalid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  p_rvalid_in_term_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (busy_o && sdio_oe_o && !sdio_do_o));

  p_term_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(sdio_oe_o && !sdio_do_o));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> $stable(rdata_o));
endmodule

bind sra_master sra_master_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .sdio_oe_o (sdio_oe_o),
  .sdio_do_o (sdio_do_o),
  .rvalid_o  (rvalid_o),
  .rdata_o   (rdata_o)
);

// File: tb/sim_sra_master.sv
`timescale 1ns/1ps
module sim_sra_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       sdio_i, oe, dout, busy, rvalid;
  logic [7:0] rdata;

  logic       phy_oe = 1'b0, phy_do = 1'b0;
  logic       r_act = 1'b0, r_rd = 1'b0;
  int         r_cnt = 0;
  logic [7:0] r_addr = '0, r_wd = '0;
  logic [7:0] pmem [256];
  logic [7:0] shadow [256];

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  assign sdio_i = oe ? dout : (phy_oe ? phy_do : 1'b1);

  sra_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .sdio_i(sdio_i), .sdio_oe_o(oe), .sdio_do_o(dout),
    .busy_o(busy), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  // far-end responder model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_act <= 1'b0; r_cnt <= 0; phy_oe <= 1'b0; phy_do <= 1'b0;
    end else if (!r_act) begin
      if (oe && dout) begin r_act <= 1'b1; r_cnt <= 1; end
    end else begin
      r_cnt <= r_cnt + 1;
      if (r_cnt == 1) r_rd <= dout;
      else if (r_cnt <= 9) r_addr <= {r_addr[6:0], dout};
      else if (r_rd) begin
        if (r_cnt <= 17) begin
          phy_oe <= 1'b1; phy_do <= pmem[r_addr][17 - r_cnt];
        end else begin
          phy_oe <= 1'b0;
          if (r_cnt == 19) r_act <= 1'b0;
        end
      end else begin
        if (r_cnt <= 17) r_wd <= {r_wd[6:0], dout};
        else begin pmem[r_addr] <= r_wd; r_act <= 1'b0; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && oe && phy_oe) chk(0, "R6 contention", 1, 0);

  function automatic logic [1:0] exp_line(input logic w, input logic [7:0] a,
                                          input logic [7:0] d, input int k);
    if (k == 0) return 2'b11;
    if (k == 1) return {1'b1, ~w};
    if (k <= 9) return {1'b1, a[9 - k]};
    if (w) return (k <= 17) ? {1'b1, d[17 - k]} : 2'b10;
    return (k <= 18) ? 2'b00 : 2'b10;
  endfunction

  // called just after a negedge with req low
  task automatic frame(input logic w, input logic [7:0] a, input logic [7:0] d,
                       input int poke_at);
    int len;
    logic [7:0] old_rd;
    len = w ? 19 : 20;
    old_rd = rdata;
    chk(!busy && !oe, "R1 idle before frame", {busy, oe}, 0);
    req = 1'b1; we = w; addr = a; wdata = d;
    for (int k = 0; k < len; k++) begin
      logic [1:0] e;
      @(negedge clk);
      e = exp_line(w, a, d, k);
      if (k == 0) chk(busy && oe && dout, "R2 start bit", {busy, oe, dout}, 3'b111);
      else if (k == 1) chk(oe == e[1] && dout == e[0], "R3 direction", {oe, dout}, e);
      else if (k <= 9) chk(oe == e[1] && dout == e[0], "R4 address bit", {oe, dout}, e);
      else if (k == len - 1) chk(oe && !dout, "R8 terminating zero", {oe, dout}, 2'b10);
      else if (w) chk(oe && dout == e[0], "R5 write bit", {oe, dout}, e);
      else chk(!oe, "R6 line released", oe, 0);
      chk(busy, "R10 busy in frame", busy, 1);
      if (!w && k == len - 1) begin
        chk(rvalid, "R7 rvalid pulse", rvalid, 1);
        chk(rdata == shadow[a], "R7 read data", rdata, shadow[a]);
      end else begin
        chk(!rvalid, "R7 no stray rvalid", rvalid, 0);
        chk(rdata == old_rd, "R11 rdata held", rdata, old_rd);
      end
      if (k == poke_at) begin
        req = 1'b1; we = ~w; addr = ~a; wdata = ~d;
      end else begin
        req = 1'b0; we = w; addr = a; wdata = d;
      end
    end
    @(negedge clk);
    req = 1'b0;
    chk(!busy && !oe && !rvalid, "R10 frame length", {busy, oe, rvalid}, 0);
    if (w) shadow[a] = d;
  endtask

  localparam logic [16:0] VEC [13] = '{
    {1'b1, 8'h06, 8'h00}, {1'b1, 8'h20, 8'h1B}, {1'b1, 8'h21, 8'h86},
    {1'b0, 8'h20, 8'h00}, {1'b0, 8'h21, 8'h00}, {1'b0, 8'h06, 8'h00},
    {1'b0, 8'hFF, 8'h00}, {1'b1, 8'hFF, 8'hFF}, {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h00, 8'h00}, {1'b0, 8'h00, 8'h00}, {1'b1, 8'h80, 8'h01},
    {1'b0, 8'h80, 8'h00}
  };

  initial begin
    #400000;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      pmem[i] = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    chk(!busy && !oe && !rvalid && rdata == 0, "R1 reset state", {busy, oe, rvalid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !oe, "R1 idle after reset", {busy, oe}, 0);

    foreach (VEC[i]) frame(VEC[i][16], VEC[i][15:8], VEC[i][7:0], -1);

    // R9: request raised mid-frame and in the terminating cycle
    frame(1'b1, 8'h33, 8'hC4, 5);
    repeat (24) begin
      @(negedge clk);
      chk(!busy && !oe, "R9 refused request left no frame", {busy, oe}, 0);
    end
    frame(1'b0, 8'h33, 8'h00, 12);
    frame(1'b1, 8'h44, 8'h7E, 18);
    @(negedge clk);
    chk(!busy && !oe, "R9 late request refused", {busy, oe}, 0);
    frame(1'b0, 8'h44, 8'h00, -1);

    // R10: held request, one idle cycle between frames
    req = 1'b1; we = 1'b1; addr = 8'h55; wdata = 8'hAA;
    repeat (19) @(negedge clk);
    @(negedge clk);
    chk(!busy && !oe, "R10 idle gap", {busy, oe}, 0);
    @(negedge clk);
    chk(busy && oe && dout, "R10 next start after one idle", {busy, oe, dout}, 3'b111);
    req = 1'b0;
    while (busy) @(negedge clk);
    shadow[8'h55] = 8'hAA;
    frame(1'b0, 8'h55, 8'h00, -1);

    // R1: reset in the middle of a frame
    req = 1'b1; we = 1'b0; addr = 8'h12;
    @(negedge clk); req = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(!busy && !oe && !rvalid, "R1 async reset mid-frame", {busy, oe, rvalid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    frame(1'b0, 8'h12, 8'h00, -1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule